// File: doc/BRIEF.md
# Staggered Split-Half Pipelined Adder

This block adds two 32-bit integers in three clocked stages. The first stage adds the lower 16 bits. The second stage adds the upper 16 bits, using the carry that the first stage registered. The third stage derives zero, sign, carry and signed-overflow flags from the finished sum. A new add may issue on every cycle. Each operation carries a valid bit through the stages, so an idle issue slot (a bubble) travels down the pipe and never raises a result strobe.

Each operand can either be taken from the issue port or be forwarded from the add issued on the cycle before. The issue port gives, for each operand, a use bit and a source tag. If the use bit is set and the source tag equals the destination tag of the valid add issued one cycle earlier, that operand's source is SRC_FWD. Otherwise its source is SRC_PORT. With SRC_FWD, the lower half is taken from the stage-1 result and, one cycle later, the upper half from the stage-2 result. A dependent add therefore starts as soon as its producer's lower half exists, and the two can run back to back.

Each add's operand source is fixed at issue. It is held in the enumerated type `opnd_src_e` (SRC_PORT or SRC_FWD) and travels with the operation. It has no transitions of its own.

Top module: `split_add_pipe`

## Requirements
- R1: After reset, fwd_lo_valid, fwd_hi_valid and res_valid are all 0.
- R2: One cycle after a valid issue, fwd_lo_valid is 1, fwd_lo_tag equals the issued destination tag, and fwd_lo_data equals bits [15:0] of the sum of the effective operands.
- R3: Two cycles after a valid issue, fwd_hi_valid is 1 with the same tag. fwd_hi_data equals bits [31:16] of the sum, including the carry out of bit 15.
- R4: Three cycles after a valid issue, res_valid is 1, res_tag is the issued tag and res_sum is the sum modulo 2^32. One add may issue per cycle.
- R5: With res_valid, res_zero is 1 when res_sum is 0, and res_sign equals res_sum bit 31. res_carry is the carry out of bit 31. res_ovf is 1 when both operands have the same bit 31 and res_sum bit 31 differs from it.
- R6: When an operand's use bit is 1 and its source tag equals the destination tag of a valid add issued in the directly preceding cycle, that operand is the full 32-bit sum of that earlier add. This holds for operand A, for operand B, and for both at once.
- R7: An operand takes the port value when its use bit is 0, when its source tag does not match, or when the preceding cycle was a bubble.
- R8: An issue with iss_valid 0 produces no fwd_lo_valid one cycle later and no res_valid three cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue slot holds an add |
| iss_tag | input | 4 | Destination tag of the issued add |
| iss_a | input | 32 | Operand A from the port |
| iss_b | input | 32 | Operand B from the port |
| iss_a_use | input | 1 | Operand A may be forwarded |
| iss_a_src | input | 4 | Source tag for operand A |
| iss_b_use | input | 1 | Operand B may be forwarded |
| iss_b_src | input | 4 | Source tag for operand B |
| fwd_lo_valid | output | 1 | Stage-1 lower-half result present |
| fwd_lo_tag | output | 4 | Tag of the stage-1 result |
| fwd_lo_data | output | 16 | Lower 16 bits of the sum |
| fwd_hi_valid | output | 1 | Stage-2 upper-half result present |
| fwd_hi_tag | output | 4 | Tag of the stage-2 result |
| fwd_hi_data | output | 16 | Upper 16 bits of the sum |
| res_valid | output | 1 | Result strobe |
| res_tag | output | 4 | Tag of the result |
| res_sum | output | 32 | 32-bit sum |
| res_zero | output | 1 | Sum is zero |
| res_sign | output | 1 | Sum bit 31 |
| res_carry | output | 1 | Carry out of bit 31 |
| res_ovf | output | 1 | Signed overflow |

## Verification
Two things share a cycle in this block. A dependent add's lower-half addition uses the stage-1 forward, while its producer's upper half is being formed from that producer's registered carry. One cycle later, the dependent's upper half uses the stage-2 forward in the same cycle the producer's flags are computed. The bench provokes this by walking a vector table with no gaps between issues, in which dependent adds follow producers whose lower halves carry into the upper half. It judges each result by checking res_sum, tag and flags against a bench-side model that resolves forwarding from the previous issue. Additional vectors place a bubble before a matching tag, or clear the use bit, to confirm that no forwarding happens in those cases.

// File: rtl/split_add_pkg.sv
package split_add_pkg;
    // Where an operand of an issued add comes from
    typedef enum logic {
        SRC_PORT = 1'b0,
        SRC_FWD  = 1'b1
    } opnd_src_e;
endpackage

// File: rtl/split_add_lo.sv
module split_add_lo
    import split_add_pkg::*;
#(
    parameter int W     = 32,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [W-1:0]     in_a,
    input  logic [W-1:0]     in_b,
    input  opnd_src_e        in_sel_a,
    input  opnd_src_e        in_sel_b,
    output logic             q_valid,
    output logic [TAG_W-1:0] q_tag,
    output logic [W/2-1:0]   q_lo,
    output logic             q_carry,
    output logic [W/2-1:0]   q_hi_a,
    output logic [W/2-1:0]   q_hi_b,
    output opnd_src_e        q_sel_a,
    output opnd_src_e        q_sel_b
);
    localparam int HALF = W / 2;

    logic [HALF-1:0] lo_a;
    logic [HALF-1:0] lo_b;
    logic [HALF:0]   lo_full;

    always_comb begin
        lo_a    = (in_sel_a == SRC_FWD) ? q_lo : in_a[HALF-1:0];
        lo_b    = (in_sel_b == SRC_FWD) ? q_lo : in_b[HALF-1:0];
        lo_full = {1'b0, lo_a} + {1'b0, lo_b};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
            q_lo    <= '0;
            q_carry <= 1'b0;
            q_hi_a  <= '0;
            q_hi_b  <= '0;
            q_sel_a <= SRC_PORT;
            q_sel_b <= SRC_PORT;
        end else begin
            q_valid <= in_valid;
            q_tag   <= in_tag;
            q_lo    <= lo_full[HALF-1:0];
            q_carry <= lo_full[HALF];
            q_hi_a  <= in_a[W-1:HALF];
            q_hi_b  <= in_b[W-1:HALF];
            q_sel_a <= in_sel_a;
            q_sel_b <= in_sel_b;
        end
    end
endmodule

// File: rtl/split_add_hi.sv
module split_add_hi
    import split_add_pkg::*;
#(
    parameter int W     = 32,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [W/2-1:0]   in_lo,
    input  logic             in_carry,
    input  logic [W/2-1:0]   in_hi_a,
    input  logic [W/2-1:0]   in_hi_b,
    input  opnd_src_e        in_sel_a,
    input  opnd_src_e        in_sel_b,
    output logic             q_valid,
    output logic [TAG_W-1:0] q_tag,
    output logic [W-1:0]     q_sum,
    output logic             q_cout,
    output logic             q_a_msb,
    output logic             q_b_msb
);
    localparam int HALF = W / 2;

    logic [HALF-1:0] hi_a;
    logic [HALF-1:0] hi_b;
    logic [HALF:0]   hi_full;

    always_comb begin
        hi_a    = (in_sel_a == SRC_FWD) ? q_sum[W-1:HALF] : in_hi_a;
        hi_b    = (in_sel_b == SRC_FWD) ? q_sum[W-1:HALF] : in_hi_b;
        hi_full = {1'b0, hi_a} + {1'b0, hi_b} + {{HALF{1'b0}}, in_carry};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
            q_sum   <= '0;
            q_cout  <= 1'b0;
            q_a_msb <= 1'b0;
            q_b_msb <= 1'b0;
        end else begin
            q_valid <= in_valid;
            q_tag   <= in_tag;
            q_sum   <= {hi_full[HALF-1:0], in_lo};
            q_cout  <= hi_full[HALF];
            q_a_msb <= hi_a[HALF-1];
            q_b_msb <= hi_b[HALF-1];
        end
    end
endmodule

// File: rtl/split_add_flags.sv
module split_add_flags #(
    parameter int W     = 32,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [W-1:0]     in_sum,
    input  logic             in_cout,
    input  logic             in_a_msb,
    input  logic             in_b_msb,
    output logic             q_valid,
    output logic [TAG_W-1:0] q_tag,
    output logic [W-1:0]     q_sum,
    output logic             q_zero,
    output logic             q_sign,
    output logic             q_carry,
    output logic             q_ovf
);
    logic zero_c;
    logic ovf_c;

    always_comb begin
        zero_c = (in_sum == '0);
        ovf_c  = (in_a_msb == in_b_msb) && (in_sum[W-1] != in_a_msb);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
            q_sum   <= '0;
            q_zero  <= 1'b0;
            q_sign  <= 1'b0;
            q_carry <= 1'b0;
            q_ovf   <= 1'b0;
        end else begin
            q_valid <= in_valid;
            q_tag   <= in_tag;
            q_sum   <= in_sum;
            q_zero  <= zero_c;
            q_sign  <= in_sum[W-1];
            q_carry <= in_cout;
            q_ovf   <= ovf_c;
        end
    end
endmodule

// File: rtl/split_add_pipe.sv
module split_add_pipe
    import split_add_pkg::*;
#(
    parameter int W     = 32,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic [W-1:0]     iss_a,
    input  logic [W-1:0]     iss_b,
    input  logic             iss_a_use,
    input  logic [TAG_W-1:0] iss_a_src,
    input  logic             iss_b_use,
    input  logic [TAG_W-1:0] iss_b_src,
    output logic             fwd_lo_valid,
    output logic [TAG_W-1:0] fwd_lo_tag,
    output logic [W/2-1:0]   fwd_lo_data,
    output logic             fwd_hi_valid,
    output logic [TAG_W-1:0] fwd_hi_tag,
    output logic [W/2-1:0]   fwd_hi_data,
    output logic             res_valid,
    output logic [TAG_W-1:0] res_tag,
    output logic [W-1:0]     res_sum,
    output logic             res_zero,
    output logic             res_sign,
    output logic             res_carry,
    output logic             res_ovf
);
    localparam int HALF = W / 2;

    opnd_src_e       sel_a;
    opnd_src_e       sel_b;

    logic             s1_valid;
    logic [TAG_W-1:0] s1_tag;
    logic [HALF-1:0]  s1_lo;
    logic             s1_carry;
    logic [HALF-1:0]  s1_hi_a;
    logic [HALF-1:0]  s1_hi_b;
    opnd_src_e        s1_sel_a;
    opnd_src_e        s1_sel_b;

    logic             s2_valid;
    logic [TAG_W-1:0] s2_tag;
    logic [W-1:0]     s2_sum;
    logic             s2_cout;
    logic             s2_a_msb;
    logic             s2_b_msb;

    // Operand source decision at issue: only the add one cycle ahead can feed
    always_comb begin
        sel_a = (iss_a_use && s1_valid && (iss_a_src == s1_tag)) ? SRC_FWD : SRC_PORT;
        sel_b = (iss_b_use && s1_valid && (iss_b_src == s1_tag)) ? SRC_FWD : SRC_PORT;
    end

    split_add_lo #(.W(W), .TAG_W(TAG_W)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (iss_valid),
        .in_tag   (iss_tag),
        .in_a     (iss_a),
        .in_b     (iss_b),
        .in_sel_a (sel_a),
        .in_sel_b (sel_b),
        .q_valid  (s1_valid),
        .q_tag    (s1_tag),
        .q_lo     (s1_lo),
        .q_carry  (s1_carry),
        .q_hi_a   (s1_hi_a),
        .q_hi_b   (s1_hi_b),
        .q_sel_a  (s1_sel_a),
        .q_sel_b  (s1_sel_b)
    );

    split_add_hi #(.W(W), .TAG_W(TAG_W)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s1_valid),
        .in_tag   (s1_tag),
        .in_lo    (s1_lo),
        .in_carry (s1_carry),
        .in_hi_a  (s1_hi_a),
        .in_hi_b  (s1_hi_b),
        .in_sel_a (s1_sel_a),
        .in_sel_b (s1_sel_b),
        .q_valid  (s2_valid),
        .q_tag    (s2_tag),
        .q_sum    (s2_sum),
        .q_cout   (s2_cout),
        .q_a_msb  (s2_a_msb),
        .q_b_msb  (s2_b_msb)
    );

    split_add_flags #(.W(W), .TAG_W(TAG_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s2_valid),
        .in_tag   (s2_tag),
        .in_sum   (s2_sum),
        .in_cout  (s2_cout),
        .in_a_msb (s2_a_msb),
        .in_b_msb (s2_b_msb),
        .q_valid  (res_valid),
        .q_tag    (res_tag),
        .q_sum    (res_sum),
        .q_zero   (res_zero),
        .q_sign   (res_sign),
        .q_carry  (res_carry),
        .q_ovf    (res_ovf)
    );

    always_comb begin
        fwd_lo_valid = s1_valid;
        fwd_lo_tag   = s1_tag;
        fwd_lo_data  = s1_lo;
        fwd_hi_valid = s2_valid;
        fwd_hi_tag   = s2_tag;
        fwd_hi_data  = s2_sum[W-1:HALF];
    end
endmodule

// File: rtl/split_add_chk.sv
module split_add_chk #(
    parameter int W     = 32,
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [TAG_W-1:0] iss_tag,
    input logic             fwd_lo_valid,
    input logic [TAG_W-1:0] fwd_lo_tag,
    input logic [W/2-1:0]   fwd_lo_data,
    input logic             fwd_hi_valid,
    input logic [TAG_W-1:0] fwd_hi_tag,
    input logic [W/2-1:0]   fwd_hi_data,
    input logic             res_valid,
    input logic [TAG_W-1:0] res_tag,
    input logic [W-1:0]     res_sum
);
    localparam int HALF = W / 2;

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2
    lo_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> (fwd_lo_valid && fwd_lo_tag == $past(iss_tag)));

    // R8
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |=> !fwd_lo_valid);

    // R3
    hi_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_lo_valid |=> (fwd_hi_valid && fwd_hi_tag == $past(fwd_lo_tag)));

    // R4
    res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hi_valid |=> (res_valid && res_tag == $past(fwd_hi_tag)
                          && res_sum[W-1:HALF] == $past(fwd_hi_data)));

    // R2
    lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && res_valid) |-> res_sum[HALF-1:0] == $past(fwd_lo_data, 2));

    // R8
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && res_valid) |-> $past(iss_valid, 3));
endmodule

bind split_add_pipe split_add_chk #(.W(W), .TAG_W(TAG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_valid    (iss_valid),
    .iss_tag      (iss_tag),
    .fwd_lo_valid (fwd_lo_valid),
    .fwd_lo_tag   (fwd_lo_tag),
    .fwd_lo_data  (fwd_lo_data),
    .fwd_hi_valid (fwd_hi_valid),
    .fwd_hi_tag   (fwd_hi_tag),
    .fwd_hi_data  (fwd_hi_data),
    .res_valid    (res_valid),
    .res_tag      (res_tag),
    .res_sum      (res_sum)
);

// File: tb/split_add_pipe_tb.sv
module split_add_pipe_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 32;
    localparam int TAG_W = 4;
    localparam int NVEC  = 12;
    localparam int VBITS = 1 + W + W + TAG_W + 1 + TAG_W + 1 + TAG_W;

    // {valid, a, b, tag, a_use, a_src, b_use, b_src}
    localparam logic [VBITS-1:0] VEC [0:NVEC-1] = '{
        {1'b1, 32'h0000_0001, 32'h0000_0002, 4'd1, 1'b0, 4'd0, 1'b0, 4'd0},
        {1'b1, 32'h0000_FFFF, 32'h0000_0001, 4'd2, 1'b0, 4'd0, 1'b0, 4'd0},
        {1'b1, 32'h0000_0000, 32'h0000_0005, 4'd3, 1'b1, 4'd2, 1'b0, 4'd0},
        {1'b1, 32'h0000_0000, 32'h7FFF_FFFF, 4'd4, 1'b1, 4'd3, 1'b0, 4'd0},
        {1'b0, 32'h0000_0000, 32'h0000_0000, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0},
        {1'b1, 32'h0000_0007, 32'h0000_0000, 4'd5, 1'b1, 4'd4, 1'b0, 4'd0},
        {1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 4'd6, 1'b0, 4'd0, 1'b0, 4'd0},
        {1'b1, 32'h8000_0000, 32'h8000_0000, 4'd7, 1'b0, 4'd0, 1'b0, 4'd0},
        {1'b1, 32'h1234_5678, 32'h0000_0000, 4'd8, 1'b1, 4'd9, 1'b0, 4'd0},
        {1'b1, 32'hDEAD_0000, 32'h0000_BEEF, 4'd9, 1'b1, 4'd8, 1'b1, 4'd8},
        {1'b1, 32'h0000_FFFF, 32'hFFFF_0001, 4'd10, 1'b0, 4'd0, 1'b0, 4'd0},
        {1'b1, 32'h0000_0005, 32'h0000_0000, 4'd11, 1'b0, 4'd10, 1'b0, 4'd10}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             iss_valid;
    logic [TAG_W-1:0] iss_tag;
    logic [W-1:0]     iss_a;
    logic [W-1:0]     iss_b;
    logic             iss_a_use;
    logic [TAG_W-1:0] iss_a_src;
    logic             iss_b_use;
    logic [TAG_W-1:0] iss_b_src;
    logic             fwd_lo_valid;
    logic [TAG_W-1:0] fwd_lo_tag;
    logic [W/2-1:0]   fwd_lo_data;
    logic             fwd_hi_valid;
    logic [TAG_W-1:0] fwd_hi_tag;
    logic [W/2-1:0]   fwd_hi_data;
    logic             res_valid;
    logic [TAG_W-1:0] res_tag;
    logic [W-1:0]     res_sum;
    logic             res_zero;
    logic             res_sign;
    logic             res_carry;
    logic             res_ovf;

    int checks = 0;
    int errors = 0;

    // Reference scoreboard
    logic [W-1:0]     exp_sum   [0:63];
    logic [TAG_W-1:0] exp_tag   [0:63];
    logic [3:0]       exp_flags [0:63];
    logic             exp_fwd   [0:63];
    int               wr_ptr = 0;
    int               rd_ptr = 0;
    logic             prev_v = 1'b0;
    logic [TAG_W-1:0] prev_tag = '0;
    logic [W-1:0]     prev_sum = '0;
    logic             mon_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_add_pipe #(.W(W), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_a(iss_a), .iss_b(iss_b),
        .iss_a_use(iss_a_use), .iss_a_src(iss_a_src),
        .iss_b_use(iss_b_use), .iss_b_src(iss_b_src),
        .fwd_lo_valid(fwd_lo_valid), .fwd_lo_tag(fwd_lo_tag), .fwd_lo_data(fwd_lo_data),
        .fwd_hi_valid(fwd_hi_valid), .fwd_hi_tag(fwd_hi_tag), .fwd_hi_data(fwd_hi_data),
        .res_valid(res_valid), .res_tag(res_tag), .res_sum(res_sum),
        .res_zero(res_zero), .res_sign(res_sign), .res_carry(res_carry), .res_ovf(res_ovf)
    );

    task automatic check(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one issue slot (call just after a falling edge) and record the model
    task automatic issue(input logic [VBITS-1:0] v);
        logic             vv;
        logic [W-1:0]     a, b, ea, eb;
        logic [TAG_W-1:0] tg, sa, sb;
        logic             ua, ub, fa, fb;
        logic [W:0]       full;
        {vv, a, b, tg, ua, sa, ub, sb} = v;
        iss_valid = vv; iss_a = a; iss_b = b; iss_tag = tg;
        iss_a_use = ua; iss_a_src = sa; iss_b_use = ub; iss_b_src = sb;
        fa = ua && prev_v && (sa == prev_tag);
        fb = ub && prev_v && (sb == prev_tag);
        ea = fa ? prev_sum : a;
        eb = fb ? prev_sum : b;
        full = {1'b0, ea} + {1'b0, eb};
        if (vv) begin
            exp_sum[wr_ptr]   = full[W-1:0];
            exp_tag[wr_ptr]   = tg;
            exp_flags[wr_ptr] = {full[W-1:0] == '0, full[W-1], full[W],
                                 (ea[W-1] == eb[W-1]) && (full[W-1] != ea[W-1])};
            exp_fwd[wr_ptr]   = fa || fb;
            wr_ptr++;
        end
        prev_v   = vv;
        prev_tag = tg;
        prev_sum = full[W-1:0];
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_a = '0; iss_b = '0; iss_tag = '0;
        iss_a_use = 1'b0; iss_a_src = '0; iss_b_use = 1'b0; iss_b_src = '0;
        prev_v = 1'b0;
    endtask

    // Result monitor (R4, R5, R6, R7, R8)
    always @(negedge clk) begin
        if (mon_en && res_valid) begin
            if (rd_ptr >= wr_ptr) begin
                check(1'b0, "R8 unexpected result strobe", {1'b0, res_sum}, '0);
            end else begin
                check(res_sum == exp_sum[rd_ptr] && res_tag == exp_tag[rd_ptr],
                      exp_fwd[rd_ptr] ? "R6 forwarded sum" : "R4/R7 port sum",
                      {1'b0, res_sum}, {1'b0, exp_sum[rd_ptr]});
                check({res_zero, res_sign, res_carry, res_ovf} == exp_flags[rd_ptr],
                      "R5 flags", {29'd0, res_zero, res_sign, res_carry, res_ovf},
                      {29'd0, exp_flags[rd_ptr]});
                rd_ptr++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!fwd_lo_valid && !fwd_hi_valid && !res_valid, "R1 reset valids",
              {30'd0, fwd_lo_valid, fwd_hi_valid, res_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!res_valid, "R1 idle after reset", {32'd0, res_valid}, '0);
        mon_en = 1'b1;

        // Vector walk: one issue per cycle, no gaps
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i]);
            @(negedge clk);
        end
        idle();
        repeat (5) @(negedge clk);
        check(rd_ptr == wr_ptr, "R4 every issued add returned",
              rd_ptr, wr_ptr);

        // Directed: staggered halves with carry across the split
        issue({1'b1, 32'h0001_8000, 32'h0000_8000, 4'd12, 1'b0, 4'd0, 1'b0, 4'd0});
        @(negedge clk);
        idle();
        check(fwd_lo_valid && fwd_lo_tag == 4'd12 && fwd_lo_data == 16'h0000,
              "R2 low half", {16'd0, fwd_lo_valid, fwd_lo_data}, {17'd1, 16'h0000});
        @(negedge clk);
        check(!fwd_lo_valid, "R8 bubble no low strobe", {32'd0, fwd_lo_valid}, '0);
        check(fwd_hi_valid && fwd_hi_tag == 4'd12 && fwd_hi_data == 16'h0002,
              "R3 high half with carry", {16'd0, fwd_hi_valid, fwd_hi_data}, {17'd1, 16'h0002});
        repeat (4) @(negedge clk);
        check(rd_ptr == wr_ptr, "R8 no extra results", rd_ptr, wr_ptr);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule